// File: doc/BRIEF.md
# PCMCIA Card Strobe Timing Sequencer

This block turns one decoded external-bus access into the card-side signal sequence of a PC Card style socket. Two sockets share it. Socket A lives in the fifth external area and offers only a memory-card window. Socket B lives in the sixth area and offers a memory-card window and an I/O-card window. The window is chosen by physical address bit 25. The block raises the socket's card enables, waits a programmable setup time, and then pulses exactly one strobe. That strobe is output-enable or write-enable for memory-card space, or the dedicated I/O read or I/O write strobe for I/O-card space. The block then keeps the enables up for a programmable hold time, drops them, and issues a one-cycle completion pulse.

All timing is counted in half bus cycles. A clock enable, `halfTick`, arrives at twice the bus rate and advances every phase counter. Setup and hold are each chosen from 0.5, 1.5, 2.5 or 3.5 bus cycles. The strobe lasts one bus cycle plus 0 to 10 programmed wait cycles. An external wait input can stretch it further. A byte access drives only the first card enable of the socket; a word access drives both.

Top module: `cardStrobeSeq`

## Requirements
- R1: After reset every card enable, every strobe and `done` are low.
- R2: Window decode uses `reqAddrTop`, which holds physical address bits 28..25. The value 101 with bit 25 = 0 selects socket A memory space (`cardEn1A`/`cardEn2A` with `rdStb`/`wrStb`). The value 110 with bit 25 = 0 selects socket B memory space (`cardEn1B`/`cardEn2B` with `rdStb`/`wrStb`). The value 110 with bit 25 = 1 selects socket B I/O space (`cardEn1B`/`cardEn2B` with `ioRdStb`/`ioWrStb`). Any other value is ignored: no output rises while it is requested.
- R3: With `reqWord` = 0 (byte), only the selected socket's first enable is driven. With `reqWord` = 1 (word), the second enable is driven in exactly the same cycles as the first. The other socket's enables stay low.
- R4: The card enables rise 2*`setupSel`+1 half-ticks before the strobe rises.
- R5: While `waitIn` is low, the strobe lasts 2*(W+1) half-ticks. W is `waitCnt`, with values above 10 treated as 10.
- R6: If `waitIn` is high at the strobe's last programmed half-tick, the strobe holds. It ends at the first half-tick from then on at which `waitIn` is low. With `halfTick` always high and `waitIn` high for the first N cycles of the strobe, the strobe lasts max(2*(W+1), N+1) cycles.
- R7: The card enables stay high 2*`holdSel`+1 half-ticks after the strobe falls.
- R8: `reqWrite` = 0 selects the read strobe of the window and `reqWrite` = 1 selects its write strobe. At most one of the four strobes is ever high, and a strobe is only high while a card enable is high.
- R9: `done` is high for exactly one clock, in the first cycle after the hold phase, with all card enables low. A new access is accepted no earlier than the cycle after `done`.
- R10: Phases advance only on clocks with `halfTick` high. When `halfTick` is high on every second clock, every phase lasts twice as many clocks as it does when `halfTick` is always high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| halfTick | input | 1 | Half-bus-cycle clock enable |
| reqValid | input | 1 | Access request, held until the card enables rise |
| reqAddrTop | input | 4 | Physical address bits 28..25 |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWord | input | 1 | 1 = word access, 0 = byte access |
| setupSel | input | 2 | Setup time select, 2*value+1 half-ticks |
| holdSel | input | 2 | Hold time select, 2*value+1 half-ticks |
| waitCnt | input | 4 | Programmed wait cycles, clamped to 10 |
| waitIn | input | 1 | External wait, stretches the strobe while high |
| cardEn1A | output | 1 | Socket A first card enable (active high) |
| cardEn2A | output | 1 | Socket A second card enable |
| cardEn1B | output | 1 | Socket B first card enable |
| cardEn2B | output | 1 | Socket B second card enable |
| rdStb | output | 1 | Memory-window output enable |
| wrStb | output | 1 | Memory-window write enable |
| ioRdStb | output | 1 | I/O-window read strobe |
| ioWrStb | output | 1 | I/O-window write strobe |
| done | output | 1 | One-clock completion pulse |

## Verification
Each fault in the phase counter or the latched length values shows up in the same access as a setup, strobe or hold interval that is too long or too short by some number of half-ticks. The bench measures these intervals directly at the enables and strobes. A wrong latched window or direction lights the wrong enable set or strobe in the first setup or strobe cycle. A sequencer that skips or repeats its finish state moves or widens `done` relative to the falling enables, and this is visible one clock after the hold phase ends.

// File: rtl/cardSeqPkg.sv
package cardSeqPkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD,
    PH_FINISH
  } phase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic ceOn;
    logic stbOn;
    logic doneOn;
  } seqStb_t;

  typedef struct packed {
    logic hit;
    logic sockB;
    logic ioWin;
  } winDec_t;

  // addrTop = physical address bits 28..25
  function automatic winDec_t decodeWin(input logic [3:0] addrTop);
    winDec_t d;
    d.hit   = 1'b0;
    d.sockB = 1'b0;
    d.ioWin = 1'b0;
    if (addrTop[3:1] == 3'b101 && !addrTop[0]) begin
      d.hit = 1'b1;
    end else if (addrTop[3:1] == 3'b110) begin
      d.hit   = 1'b1;
      d.sockB = 1'b1;
      d.ioWin = addrTop[0];
    end
    return d;
  endfunction

endpackage

// File: rtl/cardSeqCtrl.sv
module cardSeqCtrl
  import cardSeqPkg::*;
#(
  parameter int SEL_W    = 2,
  parameter int WAIT_W   = 4,
  parameter int MAX_WAIT = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              halfTick,
  input  logic              reqValid,
  input  logic              reqHit,
  input  logic [SEL_W-1:0]  setupSel,
  input  logic [SEL_W-1:0]  holdSel,
  input  logic [WAIT_W-1:0] waitCnt,
  input  logic              waitIn,
  output seqStb_t           stb
);

  localparam int STB_MAX_HT = 2 * (MAX_WAIT + 1);
  localparam int CNT_W      = $clog2(STB_MAX_HT) + 1;
  localparam int SEL_MAX_HT = 2 * ((1 << SEL_W) - 1);

  phase_t            phase;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  stbLastQ;
  logic [CNT_W-1:0]  holdLastQ;
  logic [WAIT_W-1:0] waitEff;
  logic              accept;

  assign waitEff = (waitCnt > WAIT_W'(MAX_WAIT)) ? WAIT_W'(MAX_WAIT) : waitCnt;
  assign accept  = (phase == PH_IDLE) && reqValid && reqHit && halfTick;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase     <= PH_IDLE;
      cnt       <= '0;
      stbLastQ  <= '0;
      holdLastQ <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (accept) begin
            phase     <= PH_SETUP;
            cnt       <= CNT_W'({setupSel, 1'b0});
            stbLastQ  <= CNT_W'({waitEff, 1'b1});
            holdLastQ <= CNT_W'({holdSel, 1'b0});
          end
        end
        PH_SETUP: begin
          if (halfTick) begin
            if (cnt != '0) cnt <= cnt - 1'b1;
            else begin
              phase <= PH_STROBE;
              cnt   <= stbLastQ;
            end
          end
        end
        PH_STROBE: begin
          if (halfTick) begin
            if (cnt != '0) cnt <= cnt - 1'b1;
            else if (!waitIn) begin
              phase <= PH_HOLD;
              cnt   <= holdLastQ;
            end
          end
        end
        PH_HOLD: begin
          if (halfTick) begin
            if (cnt != '0) cnt <= cnt - 1'b1;
            else phase <= PH_FINISH;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    stb.load   = accept;
    stb.ceOn   = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
    stb.stbOn  = (phase == PH_STROBE);
    stb.doneOn = (phase == PH_FINISH);
  end

  AST_SETUP_CNT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (phase != PH_STROBE) |-> (cnt <= CNT_W'(SEL_MAX_HT))); // R4
  AST_STB_CNT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_STROBE) |-> (cnt < CNT_W'(STB_MAX_HT))); // R5
  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_STROBE && cnt == '0 && waitIn) |=> (phase == PH_STROBE)); // R6
  AST_TICK_GATES: assert property (@(posedge clk) disable iff (!rstN)
    (!halfTick && phase != PH_FINISH) |=> $stable(phase)); // R10
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_FINISH) |=> (phase == PH_IDLE)); // R9

endmodule

// File: rtl/cardSeqPath.sv
module cardSeqPath
  import cardSeqPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  seqStb_t stb,
  input  winDec_t dec,
  input  logic    reqWrite,
  input  logic    reqWord,
  output logic    cardEn1A,
  output logic    cardEn2A,
  output logic    cardEn1B,
  output logic    cardEn2B,
  output logic    rdStb,
  output logic    wrStb,
  output logic    ioRdStb,
  output logic    ioWrStb,
  output logic    done
);

  logic sockBQ, ioWinQ, writeQ, wordQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sockBQ <= 1'b0;
      ioWinQ <= 1'b0;
      writeQ <= 1'b0;
      wordQ  <= 1'b0;
    end else if (stb.load) begin
      sockBQ <= dec.sockB;
      ioWinQ <= dec.ioWin;
      writeQ <= reqWrite;
      wordQ  <= reqWord;
    end
  end

  always_comb begin
    cardEn1A = stb.ceOn && !sockBQ;
    cardEn2A = stb.ceOn && !sockBQ && wordQ;
    cardEn1B = stb.ceOn && sockBQ;
    cardEn2B = stb.ceOn && sockBQ && wordQ;
    rdStb    = stb.stbOn && !ioWinQ && !writeQ;
    wrStb    = stb.stbOn && !ioWinQ && writeQ;
    ioRdStb  = stb.stbOn && ioWinQ && !writeQ;
    ioWrStb  = stb.stbOn && ioWinQ && writeQ;
    done     = stb.doneOn;
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rdStb, wrStb, ioRdStb, ioWrStb})); // R8
  AST_STB_IN_CE: assert property (@(posedge clk) disable iff (!rstN)
    (rdStb || wrStb || ioRdStb || ioWrStb) |-> (cardEn1A || cardEn1B)); // R8
  AST_CE2_WITH_CE1: assert property (@(posedge clk) disable iff (!rstN)
    (cardEn2A || cardEn2B) |-> (cardEn1A || cardEn1B)); // R3
  AST_SOCKETS_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(cardEn1A && cardEn1B)); // R2
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !(cardEn1A || cardEn1B)); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R9

endmodule

// File: rtl/cardStrobeSeq.sv
module cardStrobeSeq
  import cardSeqPkg::*;
#(
  parameter int SEL_W    = 2,
  parameter int WAIT_W   = 4,
  parameter int MAX_WAIT = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              halfTick,
  input  logic              reqValid,
  input  logic [3:0]        reqAddrTop,
  input  logic              reqWrite,
  input  logic              reqWord,
  input  logic [SEL_W-1:0]  setupSel,
  input  logic [SEL_W-1:0]  holdSel,
  input  logic [WAIT_W-1:0] waitCnt,
  input  logic              waitIn,
  output logic              cardEn1A,
  output logic              cardEn2A,
  output logic              cardEn1B,
  output logic              cardEn2B,
  output logic              rdStb,
  output logic              wrStb,
  output logic              ioRdStb,
  output logic              ioWrStb,
  output logic              done
);

  winDec_t dec;
  seqStb_t stb;

  assign dec = decodeWin(reqAddrTop);

  cardSeqCtrl #(.SEL_W(SEL_W), .WAIT_W(WAIT_W), .MAX_WAIT(MAX_WAIT)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .halfTick (halfTick),
    .reqValid (reqValid),
    .reqHit   (dec.hit),
    .setupSel (setupSel),
    .holdSel  (holdSel),
    .waitCnt  (waitCnt),
    .waitIn   (waitIn),
    .stb      (stb)
  );

  cardSeqPath u_path (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .dec      (dec),
    .reqWrite (reqWrite),
    .reqWord  (reqWord),
    .cardEn1A (cardEn1A),
    .cardEn2A (cardEn2A),
    .cardEn1B (cardEn1B),
    .cardEn2B (cardEn2B),
    .rdStb    (rdStb),
    .wrStb    (wrStb),
    .ioRdStb  (ioRdStb),
    .ioWrStb  (ioWrStb),
    .done     (done)
  );

endmodule

// File: tb/cardStrobeSeq_bench.sv
`timescale 1ns/1ps
module cardStrobeSeq_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       halfTick = 1'b1;
  logic       reqValid = 1'b0;
  logic [3:0] reqAddrTop = '0;
  logic       reqWrite = 1'b0;
  logic       reqWord = 1'b0;
  logic [1:0] setupSel = '0;
  logic [1:0] holdSel = '0;
  logic [3:0] waitCnt = '0;
  logic       waitIn = 1'b0;
  logic cardEn1A, cardEn2A, cardEn1B, cardEn2B;
  logic rdStb, wrStb, ioRdStb, ioWrStb, done;

  int nTests = 0;
  int nFail  = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  cardStrobeSeq u_cardStrobeSeq (
    .clk(clk), .rstN(rstN), .halfTick(halfTick), .reqValid(reqValid),
    .reqAddrTop(reqAddrTop), .reqWrite(reqWrite), .reqWord(reqWord),
    .setupSel(setupSel), .holdSel(holdSel), .waitCnt(waitCnt), .waitIn(waitIn),
    .cardEn1A(cardEn1A), .cardEn2A(cardEn2A), .cardEn1B(cardEn1B), .cardEn2B(cardEn2B),
    .rdStb(rdStb), .wrStb(wrStb), .ioRdStb(ioRdStb), .ioWrStb(ioWrStb), .done(done)
  );

  task automatic chk(input string req, input string what, input int got, input int exp);
    nTests++;
    if (got != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
    end
  endtask

  // 0 = socket A memory, 1 = socket B memory, 2 = socket B I/O, 3 = ignored
  function automatic int winKind(input logic [3:0] a);
    if (a[3:1] == 3'b101 && a[0] == 1'b0) return 0;
    if (a[3:1] == 3'b110) return a[0] ? 2 : 1;
    return 3;
  endfunction

  function automatic int stbHalf(input int w);
    int we;
    we = (w > 10) ? 10 : w;
    return 2 * (we + 1);
  endfunction

  task automatic runIgnored(input logic [3:0] a);
    int seen;
    seen = 0;
    @(negedge clk);
    reqAddrTop = a; reqValid = 1'b1; halfTick = 1'b1;
    for (int t = 0; t < 10; t++) begin
      @(negedge clk);
      seen += int'(cardEn1A) + int'(cardEn2A) + int'(cardEn1B) + int'(cardEn2B)
            + int'(rdStb) + int'(wrStb) + int'(ioRdStb) + int'(ioWrStb) + int'(done);
    end
    reqValid = 1'b0;
    chk("R2", "outputs during ignored request", seen, 0);
  endtask

  task automatic runAcc(input logic [3:0] a, input logic wr, input logic wd,
                        input int s, input int h, input int w, input int nWait,
                        input bit toggle);
    int kind, step, stbExp;
    int tCeRise, tStbRise, tStbFall, tCeFall, tDone, doneCnt;
    int wrongSet, wrongStb, ce2Bad, rightStb, waitLeft, t;
    logic e1, e2, o1, o2, sGood, sOther;
    kind = winKind(a);
    step = toggle ? 2 : 1;
    stbExp = toggle ? 2 * stbHalf(w)
                    : ((stbHalf(w) > nWait + 1) ? stbHalf(w) : nWait + 1);
    tCeRise = -1; tStbRise = -1; tStbFall = -1; tCeFall = -1; tDone = -1;
    doneCnt = 0; wrongSet = 0; wrongStb = 0; ce2Bad = 0; rightStb = 0; waitLeft = 0;
    @(negedge clk);
    reqAddrTop = a; reqWrite = wr; reqWord = wd;
    setupSel = 2'(s); holdSel = 2'(h); waitCnt = 4'(w);
    reqValid = 1'b1; waitIn = 1'b0;
    t = 0;
    while (t < 400) begin
      @(negedge clk);
      halfTick = toggle ? ~halfTick : 1'b1;
      e1 = (kind == 0) ? cardEn1A : cardEn1B;
      e2 = (kind == 0) ? cardEn2A : cardEn2B;
      o1 = (kind == 0) ? cardEn1B : cardEn1A;
      o2 = (kind == 0) ? cardEn2B : cardEn2A;
      if (kind == 2) begin
        sGood  = wr ? ioWrStb : ioRdStb;
        sOther = rdStb | wrStb | (wr ? ioRdStb : ioWrStb);
      end else begin
        sGood  = wr ? wrStb : rdStb;
        sOther = ioRdStb | ioWrStb | (wr ? rdStb : wrStb);
      end
      if (o1 || o2) wrongSet++;
      if (sOther) wrongStb++;
      if (e2 != (e1 && wd)) ce2Bad++;
      if (sGood) rightStb++;
      if (done) begin doneCnt++; if (tDone < 0) tDone = t; end
      if (e1 && tCeRise < 0) begin tCeRise = t; reqValid = 1'b0; end
      if (!e1 && tCeRise >= 0 && tCeFall < 0) tCeFall = t;
      if (sGood && tStbRise < 0) begin tStbRise = t; waitLeft = nWait; end
      if (!sGood && tStbRise >= 0 && tStbFall < 0) tStbFall = t;
      if (waitLeft > 0) begin waitIn = 1'b1; waitLeft--; end
      else waitIn = 1'b0;
      if (tDone >= 0 && t > tDone + 2) break;
      t++;
    end
    reqValid = 1'b0; halfTick = 1'b1;
    chk("R4", "setup clocks", tStbRise - tCeRise, (2 * s + 1) * step);
    if (nWait > 0) chk("R6", "strobe clocks with wait", tStbFall - tStbRise, stbExp);
    else if (toggle) chk("R10", "strobe clocks at half tick rate", tStbFall - tStbRise, stbExp);
    else chk("R5", "strobe clocks", tStbFall - tStbRise, stbExp);
    chk("R7", "hold clocks", tCeFall - tStbFall, (2 * h + 1) * step);
    chk("R9", "done cycle vs enable fall", tDone, tCeFall);
    chk("R9", "done width", doneCnt, 1);
    chk("R2", "other socket enable cycles", wrongSet, 0);
    chk("R3", "second enable mismatch cycles", ce2Bad, 0);
    chk("R8", "wrong strobe cycles", wrongStb, 0);
    chk("R8", "selected strobe cycles", rightStb, stbExp);
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      nTests++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "outputs after reset",
        int'(cardEn1A) + int'(cardEn2A) + int'(cardEn1B) + int'(cardEn2B) + int'(rdStb)
        + int'(wrStb) + int'(ioRdStb) + int'(ioWrStb) + int'(done), 0);

    // directed corners
    runAcc(4'b1010, 1'b0, 1'b0, 0, 0, 0, 0, 0);
    runAcc(4'b1010, 1'b1, 1'b1, 3, 3, 10, 0, 0);
    runAcc(4'b1100, 1'b0, 1'b1, 1, 2, 3, 0, 0);
    runAcc(4'b1100, 1'b1, 1'b0, 2, 1, 15, 0, 0);   // clamp to 10
    runAcc(4'b1101, 1'b0, 1'b0, 0, 3, 1, 0, 0);
    runAcc(4'b1101, 1'b1, 1'b1, 3, 0, 0, 0, 0);
    runAcc(4'b1101, 1'b0, 1'b1, 1, 1, 0, 5, 0);     // R6: wait beyond programmed end
    runAcc(4'b1010, 1'b1, 1'b0, 0, 0, 1, 1, 0);     // R6: wait ends before end
    runAcc(4'b1100, 1'b1, 1'b1, 2, 3, 2, 0, 1);     // R10: half rate
    runAcc(4'b1101, 1'b0, 1'b0, 3, 1, 12, 0, 1);
    runIgnored(4'b1011);
    runIgnored(4'b0000);
    runIgnored(4'b1110);
    runIgnored(4'b0111);

    // random accesses
    for (int i = 0; i < 40; i++) begin
      logic [3:0] a;
      int sel, nw;
      sel = int'($urandom_range(0, 2));
      a = (sel == 0) ? 4'b1010 : ((sel == 1) ? 4'b1100 : 4'b1101);
      nw = ($urandom_range(0, 3) == 0) ? int'($urandom_range(1, 25)) : 0;
      runAcc(a, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
             int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
             int'($urandom_range(0, 15)), nw, 1'b0);
    end
    for (int i = 0; i < 8; i++) begin
      runAcc(4'b1100 | 4'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
             1'($urandom_range(0, 1)), int'($urandom_range(0, 3)),
             int'($urandom_range(0, 3)), int'($urandom_range(0, 15)), 0, 1'b1);
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule